// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits beside the instruction sequencer and decides, each time an instruction retires, whether a pending interrupt is taken. The sequencer supplies a one-cycle retirement strobe, two class flags for the retiring instruction, and the processor's global interrupt-enable bit. The interrupt controller supplies per-source request, mask and priority-group bits plus a non-maskable request line. When a request is taken, the gate raises an acknowledge pulse with the winning source index. In the same cycle it clears the global enable and the taken source's request flag. It then steps through three cycles: save the status word, save the program counter, and jump, with the vector selection held steady.

Some instructions alter the status word or the interrupt controller's flag, mask or priority registers. When one of these retires, acceptance waits for the following instruction to complete as well, so the change takes effect before any handler runs. A software break is not in that class, but it drops the global enable as it retires. At that boundary only the non-maskable line can win.

Top module: `irq_accept_gate`

## Requirements
- R1: Acceptance happens only in a cycle where `instrDone` is high and no entry sequence is in progress; `ackValid` is combinational in that cycle and is low at every other time.
- R2: When `isHoldClass` is high at a boundary, nothing is accepted, including a non-maskable request. The next boundary whose instruction is not hold-class accepts normally, and consecutive hold-class instructions keep deferring.
- R3: Maskable source i is eligible only when `reqFlags[i]` is 1, `maskFlags[i]` is 0 and `ieFlag` is 1.
- R4: Among eligible sources, those with `prioHi[i]`=1 win over those with 0. Within a group the lowest index wins, and `ackIdx` carries the winner as a binary number.
- R5: A high `nmiReq` at an accepting boundary wins over all maskable sources whatever `ieFlag` and the masks are. It gives `ackIsNmi`=1, `ackIdx`=0 and clears no request flag.
- R6: At a boundary where `isSwBreak` is high, `ieClear` is 1 and no maskable source is accepted, but a non-maskable request still is (unless R2 blocks it).
- R7: On a maskable acceptance, `ieClear` is 1 and `reqClr` is one-hot at the winner, both in the `ackValid` cycle. On no acceptance, `reqClr` is all zero.
- R8: An acceptance in cycle t gives `savePsw` in t+1, `savePc` in t+2 and `vecJump` in t+3. During `vecJump`, `vecIdx` and `vecIsNmi` carry the accepted index and kind. Boundaries during t+1..t+3 are not accepted.
- R9: After reset with `instrDone` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrDone | input | 1 | One-cycle strobe: an instruction retires |
| isHoldClass | input | 1 | Retiring instruction touches status or interrupt control state |
| isSwBreak | input | 1 | Retiring instruction is a software break |
| ieFlag | input | 1 | Global interrupt-enable bit |
| nmiReq | input | 1 | Non-maskable request |
| reqFlags | input | NUM_SRC | Per-source request flags |
| maskFlags | input | NUM_SRC | Per-source mask bits (1 = masked) |
| prioHi | input | NUM_SRC | Per-source priority group (1 = high) |
| ackValid | output | 1 | Interrupt accepted this cycle |
| ackIsNmi | output | 1 | Accepted request is the non-maskable one |
| ackIdx | output | IDX_W | Accepted maskable source index |
| ieClear | output | 1 | Clear the global enable bit |
| reqClr | output | NUM_SRC | Clear the request flag of this source |
| savePsw | output | 1 | Entry step: push the status word |
| savePc | output | 1 | Entry step: push the program counter |
| vecJump | output | 1 | Entry step: jump to the service routine |
| vecIdx | output | IDX_W | Index held for the jump |
| vecIsNmi | output | 1 | Jump is to the non-maskable handler |

## Verification
A stuck or mis-stepped entry sequencer shows at the ports within three cycles of an acknowledge. It either misses or repeats one of `savePsw`, `savePc` and `vecJump`, or it blocks the next boundary's acceptance. A wrong vector capture appears on `vecIdx` or `vecIsNmi` in the jump cycle, three cycles after the acknowledge. Gating or arbitration faults are combinational and show at the same boundary as a wrong `ackValid`, `ackIdx`, `reqClr` or `ieClear`. The bench therefore checks all four signals at every boundary of a sweep over request, mask, priority, enable and non-maskable patterns, and then follows each acceptance through its three entry steps.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef struct packed {
    logic takeMask;
    logic takeNmi;
  } gateStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PSW  = 2'd1,
    SEQ_PC   = 2'd2,
    SEQ_JUMP = 2'd3
  } seqState_t;
endpackage

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqFlags,
  input  logic [NUM_SRC-1:0] maskFlags,
  input  logic [NUM_SRC-1:0] prioHi,
  input  logic               ieFlag,
  input  gateStrobe_t        strobe,
  output logic               anyElig,
  output logic [IDX_W-1:0]   ackIdx,
  output logic [NUM_SRC-1:0] reqClr,
  output logic [IDX_W-1:0]   vecIdx,
  output logic               vecIsNmi
);
  logic [NUM_SRC-1:0] eligVec;
  logic [NUM_SRC-1:0] eligHiVec;
  logic [IDX_W-1:0]   hiIdx;
  logic [IDX_W-1:0]   loIdx;
  logic [IDX_W-1:0]   winIdx;

  assign eligVec   = reqFlags & ~maskFlags & {NUM_SRC{ieFlag}};
  assign eligHiVec = eligVec & prioHi;
  assign anyElig   = |eligVec;

  // lowest-index search inside each priority group
  always_comb begin
    hiIdx = '0;
    loIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligHiVec[i]) hiIdx = IDX_W'(i);
      if (eligVec[i])   loIdx = IDX_W'(i);
    end
  end

  assign winIdx = (|eligHiVec) ? hiIdx : loIdx;
  assign ackIdx = strobe.takeMask ? winIdx : '0;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gClr
      assign reqClr[g] = strobe.takeMask && (winIdx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecIdx   <= '0;
      vecIsNmi <= 1'b0;
    end else if (strobe.takeNmi) begin
      vecIdx   <= '0;
      vecIsNmi <= 1'b1;
    end else if (strobe.takeMask) begin
      vecIdx   <= winIdx;
      vecIsNmi <= 1'b0;
    end
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqClr)); // R7
  AST_CLR_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (|reqClr) |-> ((reqClr & ~eligVec) == '0)); // R3
  AST_HIGH_GROUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ((|reqClr) && (|eligHiVec)) |-> (|(reqClr & prioHi))); // R4
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeMask || strobe.takeNmi) |=> $stable(vecIdx) && $stable(vecIsNmi)); // R8
endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
  import irq_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        isHoldClass,
  input  logic        isSwBreak,
  input  logic        nmiReq,
  input  logic        anyElig,
  output gateStrobe_t strobe,
  output logic        ackValid,
  output logic        ackIsNmi,
  output logic        ieClear,
  output logic        savePsw,
  output logic        savePc,
  output logic        vecJump
);
  seqState_t seqQ, seqD;
  logic      boundaryOk;

  assign boundaryOk      = instrDone && !isHoldClass && (seqQ == SEQ_IDLE);
  assign strobe.takeNmi  = boundaryOk && nmiReq;
  assign strobe.takeMask = boundaryOk && !nmiReq && !isSwBreak && anyElig;

  assign ackValid = strobe.takeNmi || strobe.takeMask;
  assign ackIsNmi = strobe.takeNmi;
  assign ieClear  = ackValid || (instrDone && isSwBreak);

  always_comb begin
    seqD = seqQ;
    unique case (seqQ)
      SEQ_IDLE: if (ackValid) seqD = SEQ_PSW;
      SEQ_PSW:  seqD = SEQ_PC;
      SEQ_PC:   seqD = SEQ_JUMP;
      SEQ_JUMP: seqD = SEQ_IDLE;
      default:  seqD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqQ <= SEQ_IDLE;
    else       seqQ <= seqD;
  end

  assign savePsw = (seqQ == SEQ_PSW);
  assign savePc  = (seqQ == SEQ_PC);
  assign vecJump = (seqQ == SEQ_JUMP);

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> instrDone); // R1
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isHoldClass) |-> !ackValid); // R2
  AST_BREAK_NO_MASKABLE: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isSwBreak && ackValid) |-> ackIsNmi); // R6
  AST_BREAK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isSwBreak) |-> ieClear); // R6
  AST_ENTRY_PSW: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> savePsw); // R8
  AST_ENTRY_PC: assert property (@(posedge clk) disable iff (!rstN)
    savePsw |=> savePc); // R8
  AST_ENTRY_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    savePc |=> vecJump); // R8
  AST_NO_ACK_IN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (savePsw || savePc || vecJump) |-> !ackValid); // R8
  AST_STEPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({savePsw, savePc, vecJump})); // R8
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic               isHoldClass,
  input  logic               isSwBreak,
  input  logic               ieFlag,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] reqFlags,
  input  logic [NUM_SRC-1:0] maskFlags,
  input  logic [NUM_SRC-1:0] prioHi,
  output logic               ackValid,
  output logic               ackIsNmi,
  output logic [IDX_W-1:0]   ackIdx,
  output logic               ieClear,
  output logic [NUM_SRC-1:0] reqClr,
  output logic               savePsw,
  output logic               savePc,
  output logic               vecJump,
  output logic [IDX_W-1:0]   vecIdx,
  output logic               vecIsNmi
);
  gateStrobe_t strobe;
  logic        anyElig;

  irq_gate_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .instrDone   (instrDone),
    .isHoldClass (isHoldClass),
    .isSwBreak   (isSwBreak),
    .nmiReq      (nmiReq),
    .anyElig     (anyElig),
    .strobe      (strobe),
    .ackValid    (ackValid),
    .ackIsNmi    (ackIsNmi),
    .ieClear     (ieClear),
    .savePsw     (savePsw),
    .savePc      (savePc),
    .vecJump     (vecJump)
  );

  irq_gate_dp #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqFlags  (reqFlags),
    .maskFlags (maskFlags),
    .prioHi    (prioHi),
    .ieFlag    (ieFlag),
    .strobe    (strobe),
    .anyElig   (anyElig),
    .ackIdx    (ackIdx),
    .reqClr    (reqClr),
    .vecIdx    (vecIdx),
    .vecIsNmi  (vecIsNmi)
  );
endmodule

// File: tb/irq_accept_gate_bench.sv
module irq_accept_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int IW = 2;
  localparam int WATCHDOG_CYCLES = 190000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instrDone = 1'b0;
  logic            isHoldClass = 1'b0;
  logic            isSwBreak = 1'b0;
  logic            ieFlag = 1'b0;
  logic            nmiReq = 1'b0;
  logic [NSRC-1:0] reqFlags = '0;
  logic [NSRC-1:0] maskFlags = '0;
  logic [NSRC-1:0] prioHi = '0;
  logic            ackValid, ackIsNmi, ieClear, savePsw, savePc, vecJump, vecIsNmi;
  logic [IW-1:0]   ackIdx, vecIdx;
  logic [NSRC-1:0] reqClr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_accept_gate #(.NUM_SRC(NSRC)) u_irq_accept_gate (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .isHoldClass(isHoldClass),
    .isSwBreak(isSwBreak), .ieFlag(ieFlag), .nmiReq(nmiReq), .reqFlags(reqFlags),
    .maskFlags(maskFlags), .prioHi(prioHi), .ackValid(ackValid), .ackIsNmi(ackIsNmi),
    .ackIdx(ackIdx), .ieClear(ieClear), .reqClr(reqClr), .savePsw(savePsw),
    .savePc(savePc), .vecJump(vecJump), .vecIdx(vecIdx), .vecIsNmi(vecIsNmi)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One boundary with the given inputs; expectations from the requirements.
  task automatic boundary(input logic [NSRC-1:0] rq, input logic [NSRC-1:0] mk,
                          input logic [NSRC-1:0] pr, input logic ie, input logic nmi,
                          input logic hold, input logic brk);
    logic eAck, eNmi;
    int   eIdx;
    logic [NSRC-1:0] elig, eClr;
    eAck = 1'b0; eNmi = 1'b0; eIdx = 0; eClr = '0;
    elig = rq & ~mk & {NSRC{ie}};
    if (!hold) begin
      if (nmi) begin
        eAck = 1'b1; eNmi = 1'b1;                   // R5
      end else if (!brk && (elig != 0)) begin       // R3 R6
        eAck = 1'b1;
        eIdx = -1;
        for (int i = 0; i < NSRC; i++)              // R4 high group first
          if (eIdx < 0 && elig[i] && pr[i]) eIdx = i;
        for (int i = 0; i < NSRC; i++)
          if (eIdx < 0 && elig[i]) eIdx = i;
        eClr = NSRC'(1) << eIdx;
      end
    end
    @(negedge clk);
    reqFlags = rq; maskFlags = mk; prioHi = pr; ieFlag = ie; nmiReq = nmi;
    isHoldClass = hold; isSwBreak = brk; instrDone = 1'b1;
    #1;
    check(hold ? "R2 ackValid" : "R1 ackValid", int'(ackValid), int'(eAck));
    check("R5 ackIsNmi", int'(ackIsNmi), int'(eNmi));
    check("R4 ackIdx", int'(ackIdx), eIdx);
    check("R7 reqClr", int'(reqClr), int'(eClr));
    check(brk ? "R6 ieClear" : "R7 ieClear", int'(ieClear), int'(eAck || brk));
    @(negedge clk);
    instrDone = 1'b0; isHoldClass = 1'b0; isSwBreak = 1'b0;
    if (eAck) begin
      #1;
      check("R8 savePsw", int'(savePsw), 1);
      instrDone = 1'b1; nmiReq = 1'b1;            // boundary inside entry ignored
      #1;
      check("R8 no ack in entry", int'(ackValid), 0);
      @(negedge clk);
      instrDone = 1'b0;
      #1;
      check("R8 savePc", int'(savePc), 1);
      @(negedge clk);
      #1;
      check("R8 vecJump", int'(vecJump), 1);
      check("R8 vecIdx", int'(vecIdx), eIdx);
      check("R8 vecIsNmi", int'(vecIsNmi), int'(eNmi));
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 ackValid", int'(ackValid), 0);
    check("R9 savePsw", int'(savePsw), 0);
    check("R9 reqClr", int'(reqClr), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9 ieClear", int'(ieClear), 0);
    check("R9 vecJump", int'(vecJump), 0);
    check("R9 vecIdx", int'(vecIdx), 0);

    // R1 no acceptance without a boundary
    @(negedge clk);
    reqFlags = '1; ieFlag = 1'b1; nmiReq = 1'b1;
    #1;
    check("R1 no boundary", int'(ackValid), 0);

    // full sweep of normal boundaries: R3 R4 R5 R7 R8
    for (int v = 0; v < (1 << (3 * NSRC)); v++)
      for (int c = 0; c < 4; c++)
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v >> (2 * NSRC)),
                 c[0], c[1], 1'b0, 1'b0);

    // R2 deferral and R6 software break over request/mask patterns
    for (int v = 0; v < (1 << (2 * NSRC)); v++)
      for (int c = 0; c < 4; c++) begin
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v), c[0], c[1], 1'b1, 1'b0);
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v), c[0], c[1], 1'b1, 1'b0);
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v), c[0], c[1], 1'b0, 1'b0);
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v), c[0], c[1], 1'b0, 1'b1);
        boundary(NSRC'(v), NSRC'(v >> NSRC), NSRC'(v), c[0], c[1], 1'b1, 1'b1);
      end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule